// File: doc/BRIEF.md
# Single-Sample Asynchronous Serial Byte Receiver

This block takes 8-bit asynchronous serial frames from one input line and turns them into parallel bytes. A divider runs from the 10 MHz system clock and raises a one-cycle baud enable once every 522 system clocks, which gives a bit rate close to 19.2 kbit/s. The receiver samples the line exactly once per enable. It does not oversample and does not search for the middle of a bit. The sender therefore has to keep each bit stable across the enable that samples it.

The serial input first passes through a two-flop synchroniser. A two-state machine then interprets the samples. In state `ST_IDLE` it watches for a low start bit. The transition `go_shift` is taken when an enable samples a low line, and it moves the machine to `ST_SHIFT`. In `ST_SHIFT` one data bit is captured per enable, least significant bit first. The transition `go_idle` is taken on the enable that captures the eighth bit. On that same edge the byte is copied to the output and a valid pulse one system clock long is raised. Any state value that is not recognised falls back to `ST_IDLE`. The stop bit is not checked: it is simply a high sample seen while the machine is idle.

Top module: `serial_byte_rx`

## Requirements
- R1: While `rst_n` is low, `rx_byte` is 8'h00 and `rx_valid` is 0. Asserting reset in the middle of operation clears a byte that was received earlier.
- R2: Baud enables occur every 522 system clocks. The first enable is consumed on the 261st rising clock edge after reset is released, and later ones on edges 261 + 522·k.
- R3: In `ST_IDLE`, an enable that samples a high line keeps the machine idle. Any number of idle enables produces no `rx_valid` pulse.
- R4: Data bits arrive least significant bit first. The first bit after the start bit becomes `rx_byte[0]` and the eighth becomes `rx_byte[7]`.
- R5: `rx_valid` is high for exactly one system clock per frame. It rises on the edge of the enable that captures the eighth data bit, that is, on edge s + 261 + 8·522 for a start bit driven just after edge s = 522·m.
- R6: `rx_byte` holds its value between frames until the next frame completes.
- R7: A low level on the line that begins and ends between two enables is never sampled. It starts no frame.
- R8: After the eighth bit the machine returns to `ST_IDLE`. A low sample on the very next enable starts a new frame, so a line held low continuously yields 8'h00 followed by further frames.
- R9: Frames sent back to back with a single high stop bit between them are all received, each with its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input; idles high |
| rx_byte | output | 8 | Last byte received |
| rx_valid | output | 1 | One-clock pulse when `rx_byte` is updated |

## Verification
The assertions assume that `rx_line` changes no more than once per 522-clock bit slot. They also assume that it never changes within a few clocks of a baud enable, because a sample taken during a transition could land in either bit. The stimulus meets this assumption by counting clock edges from the release of reset. Every level change on the line, including the short glitch pulses, is placed at the start of a slot, which is 261 clocks away from the enable. Random bytes and random idle gaps are sent only on that slot grid.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SHIFT = 2'b01
    } srx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RESET_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
    parameter int DIV_LAST = 260
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW     = $clog2(DIV_LAST + 1);
    localparam int PERIOD = 2 * (DIV_LAST + 1);
    localparam int GW     = $clog2(PERIOD) + 1;

    logic [CW-1:0] cnt;
    logic          phase;
    logic          wrap;

    assign wrap = (cnt == CW'(DIV_LAST));
    // an enable marks the wrap at which the half-rate phase rises
    assign tick = wrap && !phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= !phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // checker state: clocks elapsed since the previous enable
    logic [GW-1:0] gap;
    logic          seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (tick) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen) |-> (gap == GW'(PERIOD - 1)))
        else $error("enable spacing wrong");

    assert_single_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("enable lasted more than one clock");
endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_s,
    output logic [DATA_BITS-1:0] byte_out,
    output logic                 byte_valid
);
    localparam int BW = $clog2(DATA_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

    srx_state_t          state, state_nx;
    logic [BW-1:0]       bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                go_shift, go_idle;

    assign go_shift = tick && (state == ST_IDLE) && !rx_s;
    assign go_idle  = tick && (state == ST_SHIFT) && (bit_idx == LAST_BIT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go_shift) state_nx = ST_SHIFT;
            ST_SHIFT: if (go_idle)  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx    <= '0;
            shreg      <= '0;
            byte_out   <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (go_shift) begin
                bit_idx <= '0;
            end else if (tick && state == ST_SHIFT) begin
                shreg   <= {rx_s, shreg[DATA_BITS-1:1]};
                bit_idx <= bit_idx + 1'b1;
                if (go_idle) begin
                    byte_out   <= {rx_s, shreg[DATA_BITS-1:1]};
                    byte_valid <= 1'b1;
                    bit_idx    <= '0;
                end
            end
        end
    end

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_IDLE && rx_s) |=> (state == ST_IDLE))
        else $error("left idle on a high sample");

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid)
        else $error("valid longer than one clock");

    assert_valid_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(tick))
        else $error("valid without an enable");

    assert_return_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (state == ST_IDLE))
        else $error("not idle after last bit");

    assert_byte_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |-> $stable(byte_out))
        else $error("byte changed without valid");
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
    parameter int DIV_LAST    = 260,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid
);
    logic rx_s;
    logic tick;

    srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    srx_tick_gen #(.DIV_LAST(DIV_LAST)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    srx_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_s      (rx_s),
        .byte_out  (rx_byte),
        .byte_valid(rx_valid)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (rx_byte == '0 && !rx_valid)
                else $error("outputs not cleared in reset");
        end
    end
endmodule

// File: tb/serial_byte_rx_test.sv
module serial_byte_rx_test;
    localparam int CLK_PERIOD = 100;
    localparam int SLOT       = 522;
    localparam int HALF       = 261;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int checks = 0;
    int errors = 0;
    int edge_no;
    int pulses = 0;
    int last_edge = -1;
    logic [7:0] last_byte = 8'h00;
    logic prev_valid = 1'b0;

    serial_byte_rx uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_line (rx_line),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_no <= 0;
        else        edge_no <= edge_no + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && prev_valid) begin
                errors++;
                $display("FAIL R5 valid wide at edge %0d: got 1 expected 0", edge_no);
            end
            if (rx_valid) begin
                pulses++;
                last_byte = rx_byte;
                last_edge = edge_no;
            end
        end
        prev_valid = rx_valid;
    end

    function automatic int exp_valid_edge(input int start_edge);
        return start_edge + HALF + 8 * SLOT;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_slot(output int s);
        forever begin
            @(posedge clk);
            #1;
            if (edge_no % SLOT == 0) break;
        end
        s = edge_no;
    endtask

    task automatic send_frame(input logic [7:0] b, input int gap, input string req);
        int s, t, p0;
        p0 = pulses;
        next_slot(s);
        rx_line = 1'b0;
        for (int i = 0; i < 8; i++) begin
            next_slot(t);
            rx_line = b[i];
        end
        next_slot(t);
        rx_line = 1'b1;
        check({req, " pulse count"}, pulses - p0, 1);
        check({req, " byte"}, int'(last_byte), int'(b));
        check({req, " timing R2 R5"}, last_edge, exp_valid_edge(s));
        for (int g = 0; g < gap; g++) next_slot(t);
    endtask

    initial begin
        int s, t, p0;
        logic [7:0] rb;
        void'($urandom(32'd1234));
        #(CLK_PERIOD * 3 + CLK_PERIOD/2);
        // R1: reset state
        check("R1 reset byte", int'(rx_byte), 0);
        check("R1 reset valid", int'(rx_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: idle line for several enables
        p0 = pulses;
        for (int i = 0; i < 3; i++) next_slot(t);
        check("R3 idle no valid", pulses - p0, 0);

        // R4: LSB-first directed patterns
        send_frame(8'h01, 0, "R4 bit0");
        send_frame(8'h80, 1, "R4 bit7");
        send_frame(8'hA5, 0, "R4 a5");

        // R6: byte holds through idle
        for (int i = 0; i < 2; i++) next_slot(t);
        check("R6 hold byte", int'(rx_byte), 8'hA5);

        // R7: glitch between enables
        p0 = pulses;
        next_slot(s);
        rx_line = 1'b0;
        repeat (100) @(posedge clk);
        #1 rx_line = 1'b1;
        for (int i = 0; i < 12; i++) next_slot(t);
        check("R7 glitch ignored", pulses - p0, 0);
        check("R7 byte unchanged", int'(rx_byte), 8'hA5);

        // R8: line stuck low for ten slots, then high
        p0 = pulses;
        next_slot(s);
        rx_line = 1'b0;
        for (int i = 0; i < 10; i++) next_slot(t);
        rx_line = 1'b1;
        for (int i = 0; i < 10; i++) next_slot(t);
        check("R8 two frames", pulses - p0, 2);
        check("R8 second byte", int'(last_byte), 8'hFF);
        check("R8 second timing", last_edge, exp_valid_edge(s + 9 * SLOT));

        // R9: back-to-back frames
        send_frame(8'h3C, 0, "R9 b2b first");
        send_frame(8'hC3, 0, "R9 b2b second");

        // random bytes with random gaps
        for (int i = 0; i < 10; i++) begin
            rb = 8'($urandom);
            send_frame(rb, int'($urandom % 3), "R4 random");
        end

        // R1: reset mid-run clears the byte
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid reset byte", int'(rx_byte), 0);
        check("R1 mid reset valid", int'(rx_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        send_frame(8'h5A, 0, "R2 after reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule